// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block steps a floating-point operation across a short vector of registers. A start pulse brings in a destination index, two source indices, a length field, a stride field, a scalar-only flag and an undefined-operation flag. From the next cycle on, the block sends one register-index triple per cycle to an external execution unit. The arithmetic is not part of this block.

The register file is split into banks of four. Each index walks around the four positions of its own bank and never leaves it. A second source held in bank 0 is treated as a scalar and is sent unchanged with every element. A destination in bank 0 makes the whole operation scalar.

The execution unit answers each triple with exception flags in the same cycle. The block ORs these flags over the whole vector. One cycle after the last triple it presents the combined flags and pulses done. A request marked undefined issues nothing and completes at once with every flag set.

Top module: `svs_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, done and issue_valid are low and exc_out is zero.
- R2: A start accepted while idle puts element 0 on the issue outputs in the next cycle. The remaining elements follow in consecutive cycles with no gaps.
- R3: The number of elements issued is len_field + 1. The 3-bit field gives 1 to 8 elements.
- R4: Exactly one element is issued when scalar_only is high or when the destination is in bank 0 (dst_idx[4:2] == 0), whatever len_field holds.
- R5: The step is 2 when stride_field is 2'b11 and 1 for any other value. After each element, the destination and first source set their position bits [1:0] to (position + step) mod 4 and keep bits [4:2].
- R6: A second source in bank 0 (bits [4:2] == 0) is issued unchanged for every element. In any other bank it advances as in R5.
- R7: exc_out equals the OR of exc_in over every issuing cycle of the sequence. All elements are issued even after a flag has been returned.
- R8: done is a single-cycle pulse in the cycle after the last element. busy is high in exactly the issuing cycles, and is low when done is high.
- R9: A start with op_undef high issues nothing and keeps busy low. In the next cycle it pulses done with exc_out all ones.
- R10: A start that arrives while busy is ignored. The running sequence goes on with its own indices and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| op_undef | input | 1 | Requested operation is not implemented |
| scalar_only | input | 1 | Force a single element |
| dst_idx | input | 5 | Destination register index |
| src_a_idx | input | 5 | First source register index |
| src_b_idx | input | 5 | Second source register index |
| len_field | input | 3 | Element count minus one |
| stride_field | input | 2 | Stride select, 2'b11 selects step 2 |
| issue_valid | output | 1 | An index triple is being issued this cycle |
| issue_dst | output | 5 | Issued destination index |
| issue_a | output | 5 | Issued first-source index |
| issue_b | output | 5 | Issued second-source index |
| exc_in | input | 8 | Flags returned by the execution unit for the current triple |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| exc_out | output | 8 | Combined exception flags, valid with done |

## Verification
The bench targets position wrap inside a bank at both step sizes. A sequencer that carried into the bank bits would move an operand into the wrong bank. It checks a bank-0 second source over an 8-element run: one that advanced it would turn a scalar into a vector. A bank-0 destination with a large length field must issue a single element, and a missed override would write several registers. The bench also checks that flags returned early still let later elements issue and are still reported, that an undefined request issues nothing, and that a second start during a run does not restart or corrupt it.

// File: rtl/svs_pkg.sv
package svs_pkg;
  localparam int POS_W   = 2;
  localparam int STEP_W  = 2;
  localparam logic [1:0] WIDE_STRIDE = 2'b11;

  typedef enum logic [1:0] {
    SLOT_DST = 2'd0,
    SLOT_A   = 2'd1,
    SLOT_B   = 2'd2
  } slot_e;
endpackage

// File: rtl/svs_len_decode.sv
module svs_len_decode #(
  parameter int IDX_W = 5,
  parameter int LEN_W = 3,
  parameter int STR_W = 2
) (
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [LEN_W-1:0] len_field,
  input  logic [STR_W-1:0] stride_field,
  input  logic             scalar_only,
  output logic [LEN_W-1:0] last_cnt,
  output logic [svs_pkg::STEP_W-1:0] step
);
  localparam int BANK_W = IDX_W - svs_pkg::POS_W;

  logic dst_scalar_bank;

  always_comb begin
    dst_scalar_bank = (dst_idx[IDX_W-1 -: BANK_W] == '0);
    last_cnt = (scalar_only || dst_scalar_bank) ? '0 : len_field;
    step = (stride_field == STR_W'(svs_pkg::WIDE_STRIDE)) ? 2'd2 : 2'd1;
  end
endmodule

// File: rtl/svs_index_step.sv
module svs_index_step #(
  parameter int IDX_W = 5,
  parameter bit HOLD_IN_BANK0 = 1'b0
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [svs_pkg::STEP_W-1:0] step,
  output logic [IDX_W-1:0] nxt
);
  localparam int POS_W  = svs_pkg::POS_W;
  localparam int BANK_W = IDX_W - POS_W;

  logic [BANK_W-1:0] bank;
  logic [POS_W-1:0]  pos_wrapped;

  always_comb begin
    bank = idx[IDX_W-1 -: BANK_W];
    pos_wrapped = idx[POS_W-1:0] + POS_W'(step);
    if (HOLD_IN_BANK0 && bank == '0)
      nxt = idx;
    else
      nxt = {bank, pos_wrapped};
  end
endmodule

// File: rtl/svs_seq.sv
module svs_seq #(
  parameter int IDX_W = 5,
  parameter int LEN_W = 3,
  parameter int STR_W = 2,
  parameter int EXC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             op_undef,
  input  logic             scalar_only,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic [IDX_W-1:0] src_b_idx,
  input  logic [LEN_W-1:0] len_field,
  input  logic [STR_W-1:0] stride_field,
  output logic             issue_valid,
  output logic [IDX_W-1:0] issue_dst,
  output logic [IDX_W-1:0] issue_a,
  output logic [IDX_W-1:0] issue_b,
  input  logic [EXC_W-1:0] exc_in,
  output logic             busy,
  output logic             done,
  output logic [EXC_W-1:0] exc_out
);
  import svs_pkg::*;

  localparam int NSLOT  = 3;
  localparam int BANK_W = IDX_W - POS_W;

  logic [LEN_W-1:0]  dec_last;
  logic [STEP_W-1:0] dec_step;

  logic [IDX_W-1:0]  idx_q   [NSLOT];
  logic [IDX_W-1:0]  idx_nxt [NSLOT];
  logic [IDX_W-1:0]  idx_in  [NSLOT];
  logic [LEN_W-1:0]  remain_q;
  logic [STEP_W-1:0] step_q;
  logic [EXC_W-1:0]  acc_q;
  logic              busy_q, valid_q, done_q;
  logic [EXC_W-1:0]  exc_q;
  logic              accept;

  assign accept = start && !busy_q;
  assign idx_in[SLOT_DST] = dst_idx;
  assign idx_in[SLOT_A]   = src_a_idx;
  assign idx_in[SLOT_B]   = src_b_idx;

  svs_len_decode #(.IDX_W(IDX_W), .LEN_W(LEN_W), .STR_W(STR_W)) u_dec (
    .dst_idx      (dst_idx),
    .len_field    (len_field),
    .stride_field (stride_field),
    .scalar_only  (scalar_only),
    .last_cnt     (dec_last),
    .step         (dec_step)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    svs_index_step #(.IDX_W(IDX_W), .HOLD_IN_BANK0(g == int'(SLOT_B))) u_step (
      .idx  (idx_q[g]),
      .step (step_q),
      .nxt  (idx_nxt[g])
    );

    always_ff @(posedge clk) begin
      if (rst)
        idx_q[g] <= '0;
      else if (accept && !op_undef)
        idx_q[g] <= idx_in[g];
      else if (valid_q && remain_q != '0)
        idx_q[g] <= idx_nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      remain_q <= '0;
      step_q   <= 2'd1;
      acc_q    <= '0;
      exc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (op_undef) begin
          done_q <= 1'b1;
          exc_q  <= '1;
        end else begin
          busy_q   <= 1'b1;
          valid_q  <= 1'b1;
          remain_q <= dec_last;
          step_q   <= dec_step;
          acc_q    <= '0;
        end
      end else if (valid_q) begin
        if (remain_q == '0) begin
          valid_q <= 1'b0;
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          exc_q   <= acc_q | exc_in;
        end else begin
          remain_q <= remain_q - 1'b1;
          acc_q    <= acc_q | exc_in;
        end
      end
    end
  end

  assign issue_valid = valid_q;
  assign issue_dst   = idx_q[SLOT_DST];
  assign issue_a     = idx_q[SLOT_A];
  assign issue_b     = idx_q[SLOT_B];
  assign busy        = busy_q;
  assign done        = done_q;
  assign exc_out     = exc_q;

  assert_bank_kept_R5: assert property (@(posedge clk) disable iff (rst)
    valid_q && $past(valid_q) |->
      issue_dst[IDX_W-1 -: BANK_W] == $past(issue_dst[IDX_W-1 -: BANK_W]) &&
      issue_a[IDX_W-1 -: BANK_W] == $past(issue_a[IDX_W-1 -: BANK_W]));

  assert_b_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    valid_q && $past(valid_q) && $past(issue_b[IDX_W-1 -: BANK_W]) == '0 |-> $stable(issue_b));

  assert_single_R4: assert property (@(posedge clk) disable iff (rst)
    start && !busy_q && !op_undef && (scalar_only || dst_idx[IDX_W-1 -: BANK_W] == '0)
      |=> valid_q ##1 (done_q && !valid_q));

  assert_undef_R9: assert property (@(posedge clk) disable iff (rst)
    start && !busy_q && op_undef |=> done_q && !valid_q && !busy_q && exc_q == '1);

  assert_issue_busy_R8: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> busy_q);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q && !valid_q);
endmodule

// File: tb/test_svs_seq.sv
module test_svs_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, op_undef = 1'b0, scalar_only = 1'b0;
  logic [4:0] dst_idx = '0, src_a_idx = '0, src_b_idx = '0;
  logic [2:0] len_field = '0;
  logic [1:0] stride_field = '0;
  logic issue_valid, busy, done;
  logic [4:0] issue_dst, issue_a, issue_b;
  logic [7:0] exc_in, exc_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  // Execution-unit stub: one flag per destination position/bank bit
  assign exc_in = issue_valid ? (8'h01 << issue_dst[2:0]) : 8'h00;

  svs_seq i_svs_seq (
    .clk(clk), .rst(rst), .start(start), .op_undef(op_undef),
    .scalar_only(scalar_only), .dst_idx(dst_idx), .src_a_idx(src_a_idx),
    .src_b_idx(src_b_idx), .len_field(len_field), .stride_field(stride_field),
    .issue_valid(issue_valid), .issue_dst(issue_dst), .issue_a(issue_a),
    .issue_b(issue_b), .exc_in(exc_in), .busy(busy), .done(done), .exc_out(exc_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] adv(input logic [4:0] i, input int s, input bit hold);
    if (hold && i[4:2] == 3'd0) return i;
    return {i[4:2], 2'(i[1:0] + 2'(s))};
  endfunction

  task automatic run_seq(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                         input logic [2:0] lf, input logic [1:0] sf, input bit sc,
                         input bit inject, input string req);
    int n, s;
    logic [4:0] ed, ea, eb;
    logic [7:0] eexc;
    n = (sc || d[4:2] == 3'd0) ? 1 : int'(lf) + 1;
    s = (sf == 2'b11) ? 2 : 1;
    ed = d; ea = a; eb = b; eexc = '0;
    @(negedge clk);
    dst_idx = d; src_a_idx = a; src_b_idx = b; len_field = lf;
    stride_field = sf; scalar_only = sc; op_undef = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(issue_valid == 1'b1, req, $sformatf("issue_valid elem %0d", i), 32'(issue_valid), 1);
      chk(busy == 1'b1, "R8", $sformatf("busy elem %0d", i), 32'(busy), 1);
      chk(issue_dst == ed, req, $sformatf("dst elem %0d", i), 32'(issue_dst), 32'(ed));
      chk(issue_a == ea, req, $sformatf("srcA elem %0d", i), 32'(issue_a), 32'(ea));
      chk(issue_b == eb, "R6", $sformatf("srcB elem %0d", i), 32'(issue_b), 32'(eb));
      chk(done == 1'b0, "R8", "done during issue", 32'(done), 0);
      eexc |= 8'h01 << ed[2:0];
      ed = adv(ed, s, 1'b0); ea = adv(ea, s, 1'b0); eb = adv(eb, s, 1'b1);
      if (inject && i == 0) begin
        // R10: start while busy, with different operands
        dst_idx = 5'd20; src_a_idx = 5'd21; src_b_idx = 5'd22; len_field = 3'd0;
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, "R8", "done after last", 32'(done), 1);
    chk(issue_valid == 1'b0, "R3", "no extra element", 32'(issue_valid), 0);
    chk(busy == 1'b0, "R8", "busy with done", 32'(busy), 0);
    chk(exc_out == eexc, "R7", "combined flags", 32'(exc_out), 32'(eexc));
    @(negedge clk);
    chk(done == 1'b0, "R8", "done pulse width", 32'(done), 0);
    chk(issue_valid == 1'b0 && busy == 1'b0, inject ? "R10" : "R2", "idle after run",
        32'({issue_valid, busy}), 0);
  endtask

  task automatic test_reset();
    chk(busy == 1'b0 && done == 1'b0 && issue_valid == 1'b0, "R1", "control after reset",
        32'({busy, done, issue_valid}), 0);
    chk(exc_out == 8'h00, "R1", "exc_out after reset", 32'(exc_out), 0);
  endtask

  task automatic test_undef();
    @(negedge clk);
    dst_idx = 5'd9; src_a_idx = 5'd13; src_b_idx = 5'd17; len_field = 3'd5;
    stride_field = 2'b00; scalar_only = 1'b0; op_undef = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_undef = 1'b0;
    chk(done == 1'b1, "R9", "undef done", 32'(done), 1);
    chk(exc_out == 8'hFF, "R9", "undef flags", 32'(exc_out), 32'hFF);
    chk(issue_valid == 1'b0 && busy == 1'b0, "R9", "undef no issue", 32'({issue_valid, busy}), 0);
    @(negedge clk);
    chk(issue_valid == 1'b0 && done == 1'b0, "R9", "undef quiet after", 32'({issue_valid, done}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_seq(5'd5, 5'd9, 5'd14, 3'd3, 2'b00, 1'b0, 1'b0, "R3");   // R2 R3 R5 wrap step 1
    run_seq(5'd7, 5'd12, 5'd2, 3'd7, 2'b11, 1'b0, 1'b0, "R5");   // R5 step 2, R6 bank-0 scalar
    run_seq(5'd30, 5'd27, 5'd19, 3'd5, 2'b10, 1'b0, 1'b0, "R5"); // R5 non-ones field gives step 1
    run_seq(5'd10, 5'd6, 5'd11, 3'd4, 2'b00, 1'b1, 1'b0, "R4");  // R4 scalar_only
    run_seq(5'd3, 5'd6, 5'd11, 3'd6, 2'b11, 1'b0, 1'b0, "R4");   // R4 bank-0 destination
    test_undef();
    run_seq(5'd13, 5'd17, 5'd25, 3'd2, 2'b00, 1'b0, 1'b1, "R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule